// File: doc/BRIEF.md
# Serial Register Port with Staged Commit

This block is a serial slave that gives an external controller read and write access to a small register bank. The controller frames each access with an active-low select. It shifts in a 16-bit command word, most significant bit first, and then exchanges whole data bytes. The command word carries the direction, a length code and a 13-bit start address. Each byte after the first moves to the next address. The pins are sampled by the system clock through a short synchroniser, so the whole design runs in one clock domain.

Data written over the port goes first into a staging copy of each register. The working copy, which is the one the rest of the chip sees, is refreshed from the staging copy in a single clock, either by a commit pulse on a pin or by a self-clearing bit in the control register at address 0. Bit 0 of that control register chooses whether reads return the staging copy or the working copy. Address 0 has no staging copy: a write to it takes effect at once.

Top module: `scp_regport`

## Requirements
- R1: After reset every byte of `reg_out` is 0, and `busy`, `sdo_oe` and `sdo` are 0.
- R2: The command word is 16 bits, sampled on rising `sclk` edges, MSB first. Bit 15 = 1 means read and 0 means write. Bits 14:13 are the length code: 00 = one byte, 01 = two, 10 = three, 11 = stream. Bits 12:0 are the start address.
- R3: A write to address 1..NUM_REGS-1 changes only the staging copy. `reg_out` is unchanged until a commit.
- R4: A one-clock high on `io_update` copies every staging byte 1..NUM_REGS-1 into the working copy, which `reg_out` shows.
- R5: Address 0 is the control byte and takes effect at once. It is visible as `reg_out[7:0]`. Writing bit 1 = 1 performs a commit one clock later, and bit 1 reads back 0 after that.
- R6: A read returns the staging byte when control bit 0 is 1 and the working byte when it is 0. A read of address 0 returns the control byte.
- R7: Each completed byte advances the address by one. After the number of bytes set by length codes 00/01/10, further `sclk` pulses write nothing.
- R8: With length code 11, bytes keep transferring at successive addresses until `cs_n` goes high.
- R9: Raising `cs_n` part way through the command or a byte discards the partial bits. The next transaction starts with a fresh command word.
- R10: During a read, `sdo` presents each bit after a falling `sclk` edge, MSB first. `sdo_oe` is 1 only while read data bytes remain to be sent.
- R11: Addresses at or above NUM_REGS, including any with nonzero upper bits, ignore writes and read as 0.
- R12: `busy` rises when the command word completes. It falls after the last counted byte, or when `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial data into the block |
| io_update | input | 1 | Commit pulse, staging copy to working copy |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for `sdo`, so it can share a bidirectional pin |
| busy | output | 1 | Command accepted, data bytes outstanding |
| reg_out | output | 8*NUM_REGS | Working register bytes, byte i at bits 8i+7:8i, byte 0 is control |

## Verification
The hardest cases to reach are a select that rises part way through a command or a data byte, and a byte clocked in after the length count is used up. Both produce no visible event at the time. The bench creates them by clocking a truncated bit run and by sending a surplus byte. It then commits and compares every working byte against a model of the staging and working copies, so a stray write anywhere shows up. Staging contents are only visible through readback, so the bench flips the control select bit and reads the same address under both settings.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 13;
  localparam int CTRL_RB_BIT  = 0;
  localparam int CTRL_UPD_BIT = 1;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_t;
  typedef enum logic [1:0] {LEN_ONE = 2'b00, LEN_TWO = 2'b01,
                            LEN_THREE = 2'b10, LEN_STREAM = 2'b11} len_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              sdi_s,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy
);
  logic              sclk_d;
  logic              rise, fall;
  phase_t            phase;
  logic [CMD_W-2:0]  sh;
  logic [3:0]        bitcnt;
  logic              rw;
  len_t              len;
  logic [1:0]        left;
  logic [ADDR_W-1:0] addr;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      phase   <= PH_CMD;
      sh      <= '0;
      bitcnt  <= '0;
      rw      <= 1'b0;
      len     <= LEN_ONE;
      left    <= '0;
      addr    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_en  <= 1'b0;
      if (cs_s) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
        sdo_oe <= 1'b0;
      end else if (rise) begin
        sh     <= {sh[CMD_W-3:0], sdi_s};
        bitcnt <= bitcnt + 4'd1;
        unique case (phase)
          PH_CMD: if (bitcnt == 4'(CMD_W-1)) begin
            rw     <= sh[CMD_W-2];
            len    <= len_t'(sh[CMD_W-3:CMD_W-4]);
            left   <= sh[CMD_W-3:CMD_W-4];
            addr   <= {sh[ADDR_W-2:0], sdi_s};
            phase  <= PH_DATA;
            bitcnt <= '0;
          end
          PH_DATA: if (bitcnt[2:0] == 3'd7) begin
            bitcnt <= '0;
            addr   <= addr + 13'd1;
            if (!rw) begin
              wr_en   <= 1'b1;
              wr_addr <= addr;
              wr_data <= {sh[6:0], sdi_s};
            end
            if (len != LEN_STREAM) begin
              if (left == 2'd0) begin
                phase  <= PH_DONE;
                sdo_oe <= 1'b0;
              end else begin
                left <= left - 2'd1;
              end
            end
          end
          default: ;
        endcase
      end else if (fall && phase == PH_DATA && rw) begin
        sdo    <= rd_data[3'd7 - bitcnt[2:0]];
        sdo_oe <= 1'b1;
      end
    end
  end

  assign rd_addr = addr;
  assign busy    = (phase == PH_DATA);
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  io_update,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] reg_out,
  output logic [NUM_REGS*8-1:0] shadow_flat
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0]       ctrl_q;
  logic             commit;
  logic             rd_hit;
  logic [IDX_W-1:0] rd_idx;

  assign commit = io_update | ctrl_q[CTRL_UPD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_q[CTRL_UPD_BIT]) ctrl_q[CTRL_UPD_BIT] <= 1'b0;
      if (wr_en && wr_addr == '0) ctrl_q <= wr_data;
    end
  end

  assign shadow_flat[7:0] = ctrl_q;
  assign reg_out[7:0]     = ctrl_q;

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_reg
    logic [7:0] stage_q, work_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        work_q  <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(gi)) stage_q <= wr_data;
        if (commit) work_q <= stage_q;
      end
    end
    assign shadow_flat[8*gi +: 8] = stage_q;
    assign reg_out[8*gi +: 8]     = work_q;
  end

  assign rd_hit = 32'(rd_addr) < NUM_REGS;
  assign rd_idx = rd_addr[IDX_W-1:0];

  always_comb begin
    if (!rd_hit)                  rd_data = '0;
    else if (ctrl_q[CTRL_RB_BIT]) rd_data = shadow_flat[8*rd_idx +: 8];
    else                          rd_data = reg_out[8*rd_idx +: 8];
  end
endmodule

// File: rtl/scp_regport.sv
module scp_regport
  import scp_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  sdi,
  input  logic                  io_update,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  busy,
  output logic [NUM_REGS*8-1:0] reg_out
);
  logic                  sclk_s, cs_s, sdi_s;
  logic [ADDR_W-1:0]     rd_addr, wr_addr;
  logic [7:0]            rd_data, wr_data;
  logic                  wr_en;
  logic [NUM_REGS*8-1:0] shadow_flat;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({sclk, cs_n, sdi}),
    .q({sclk_s, cs_s, sdi_s})
  );

  scp_frame u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
  );

  scp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .io_update(io_update),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .reg_out(reg_out), .shadow_flat(shadow_flat)
  );
endmodule

// File: rtl/scp_regport_chk.sv
module scp_regport_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  io_update,
  input logic                  busy,
  input logic                  sdo_oe,
  input logic [NUM_REGS*8-1:0] reg_out,
  input logic                  cs_s,
  input logic [NUM_REGS*8-1:0] shadow_flat,
  input logic                  wr_en
);
  p_idle_after_cs_r12: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !busy);

  p_oe_needs_busy_r10: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> busy);

  p_commit_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
    reg_out[1] |=> !reg_out[1]);

  p_work_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!io_update && !reg_out[1]) |=> $stable(reg_out[NUM_REGS*8-1:8]));

  p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    io_update |=> reg_out[NUM_REGS*8-1:8] == $past(shadow_flat[NUM_REGS*8-1:8]));

  p_single_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind scp_regport scp_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .io_update(io_update), .busy(busy),
  .sdo_oe(sdo_oe), .reg_out(reg_out), .cs_s(cs_s),
  .shadow_flat(shadow_flat), .wr_en(wr_en)
);

// File: tb/test_scp_regport.sv
`timescale 1ns/1ps
module test_scp_regport;
  localparam int NR = 8;
  localparam int H  = 8;

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1, sdi = 0, io_update = 0;
  logic sdo, sdo_oe, busy;
  logic [NR*8-1:0] reg_out;
  int nchk = 0, nerr = 0;
  logic [7:0] m_sh [NR];
  logic [7:0] m_act [NR];
  logic [7:0] m_ctrl;

  always #2.5 clk = ~clk;

  scp_regport #(.NUM_REGS(NR)) i_scp_regport (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .io_update(io_update), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .reg_out(reg_out)
  );

  task automatic cw(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] exp_regs();
    logic [NR*8-1:0] v;
    v[7:0] = m_ctrl;
    for (int i = 1; i < NR; i++) v[8*i +: 8] = m_act[i];
    return v;
  endfunction

  task automatic mdl_commit();
    for (int i = 1; i < NR; i++) m_act[i] = m_sh[i];
  endtask

  task automatic mdl_wr(input logic [12:0] a, input logic [7:0] d);
    if (a == 0) begin
      m_ctrl = d;
      if (d[1]) begin mdl_commit(); m_ctrl[1] = 1'b0; end
    end else if (a < NR) m_sh[a] = d;
  endtask

  task automatic bit_x(input logic b, output logic r);
    sclk = 0; sdi = b; cw(H);
    r = sdo;
    sclk = 1; cw(H);
  endtask

  task automatic begin_tx(input logic rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    logic dmy;
    w = {rw, len, a};
    cs_n = 0; cw(4);
    for (int i = 15; i >= 0; i--) bit_x(w[i], dmy);
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_x(b[i], r[i]);
  endtask

  task automatic end_tx();
    sclk = 0; cw(H);
    cs_n = 1; cw(8);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] r;
    begin_tx(1'b0, 2'b00, a); byte_x(d, r); end_tx();
    mdl_wr(a, d);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    begin_tx(1'b1, 2'b00, a); byte_x(8'h00, d); end_tx();
  endtask

  task automatic pulse_commit();
    io_update = 1; cw(1); io_update = 0; cw(2);
    mdl_commit();
  endtask

  task automatic t_reset();
    chk("R1 reg_out", reg_out, '0);
    chk("R1 busy", busy, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sdo", sdo, 0);
  endtask

  task automatic t_staging();
    logic [7:0] d;
    wr1(13'd3, 8'hA5);
    chk("R3 write held in staging", reg_out, exp_regs());
    wr1(13'd0, 8'h01);
    rd1(13'd3, d);
    chk("R6 R2 staging readback", d, 8'hA5);
    wr1(13'd0, 8'h00);
    rd1(13'd3, d);
    chk("R6 working readback", d, 8'h00);
    rd1(13'd0, d);
    chk("R6 control readback", d, 8'h00);
  endtask

  task automatic t_commit();
    pulse_commit();
    chk("R4 commit copies staging", reg_out, exp_regs());
  endtask

  task automatic t_burst();
    logic [7:0] r;
    begin_tx(1'b0, 2'b10, 13'd4);
    byte_x(8'h11, r); byte_x(8'h22, r);
    chk("R12 busy mid burst", busy, 1);
    byte_x(8'h33, r);
    chk("R12 busy after count", busy, 0);
    byte_x(8'h44, r);
    end_tx();
    mdl_wr(13'd4, 8'h11); mdl_wr(13'd5, 8'h22); mdl_wr(13'd6, 8'h33);
    pulse_commit();
    chk("R7 three byte burst, surplus ignored", reg_out, exp_regs());
  endtask

  task automatic t_stream();
    logic [7:0] r;
    begin_tx(1'b0, 2'b11, 13'd1);
    for (int i = 1; i <= 5; i++) begin
      byte_x(8'h60 + 8'(i), r);
      mdl_wr(13'(i), 8'h60 + 8'(i));
    end
    chk("R8 busy while streaming", busy, 1);
    end_tx();
    chk("R3 stream not yet visible", reg_out, exp_regs());
    wr1(13'd0, 8'h02);
    cw(2);
    chk("R5 control bit commit", reg_out, exp_regs());
    rd1(13'd0, r);
    chk("R5 commit bit self cleared", r, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] d0, d1, d2;
    begin_tx(1'b1, 2'b11, 13'd4);
    byte_x(8'h00, d0);
    chk("R10 sdo_oe during read", sdo_oe, 1);
    byte_x(8'h00, d1); byte_x(8'h00, d2);
    end_tx();
    chk("R8 stream read byte 0", d0, 8'h64);
    chk("R8 stream read byte 1", d1, 8'h65);
    chk("R8 stream read byte 2", d2, 8'h33);
    chk("R10 sdo_oe after deselect", sdo_oe, 0);
    begin_tx(1'b1, 2'b00, 13'd6);
    byte_x(8'h00, d0);
    cw(2);
    chk("R10 sdo_oe off after count", sdo_oe, 0);
    end_tx();
    chk("R10 single read data", d0, 8'h33);
  endtask

  task automatic t_abort();
    logic dmy;
    cs_n = 0; cw(4);
    for (int i = 0; i < 7; i++) bit_x(1'b1, dmy);
    sclk = 0; cw(H); cs_n = 1; cw(8);
    chk("R9 idle after command abort", busy, 0);
    begin_tx(1'b0, 2'b00, 13'd7);
    for (int i = 0; i < 5; i++) bit_x(1'b1, dmy);
    sclk = 0; cw(H); cs_n = 1; cw(8);
    chk("R9 idle after data abort", busy, 0);
    wr1(13'd2, 8'h3C);
    pulse_commit();
    chk("R9 partial byte dropped, next command ok", reg_out, exp_regs());
  endtask

  task automatic t_range();
    logic [7:0] d;
    wr1(13'h1FF0, 8'hEE);
    wr1(13'h1002, 8'h77);
    wr1(13'd0, 8'h01);
    rd1(13'h1FF0, d);
    chk("R11 high address reads zero", d, 8'h00);
    rd1(13'h1002, d);
    chk("R11 no alias on read", d, 8'h00);
    pulse_commit();
    chk("R11 writes ignored", reg_out, exp_regs());
    wr1(13'd0, 8'h00);
  endtask

  initial begin
    m_ctrl = '0;
    for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    rst = 1; cw(5); rst = 0; cw(5);
    t_reset();
    t_staging();
    t_commit();
    t_burst();
    t_stream();
    t_read();
    t_abort();
    t_range();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule